// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Arbitration

This block is a true dual-port static memory, 2048 words of 8 bits by default. It has two fully independent ports, called left and right. Each port carries its own enable, write strobe (active low), output enable, address and write data. It returns read data, a read-valid flag and an active-low busy flag.

The whole block runs on a single clock. Inputs are sampled at a rising edge. Every output seen in the following cycle describes the access sampled at that edge.

An arbiter watches for both enabled ports addressing the same word. The port that settled on that word first is granted. The other port is flagged busy, and any write it attempts is suppressed inside the array. Reads are never suppressed. Busy exists so that the system can stall the losing port, or treat the collision as an event worth reporting.

Top module: `dpram_arb`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (2048 x 8 by default). A word written at any address is returned unchanged by a later read of that address from either port.
- R2: A port whose enable is low performs no write, whatever its write strobe or output enable. In the next cycle its read-valid is 0 and its read data is all zeros.
- R3: A port with enable 1 and write strobe 0 stores its write data at the addressed word on that edge. The exception is when the port loses arbitration on that edge; then memory is left unchanged. Two ports writing different addresses on the same edge both commit.
- R4: A port with enable 1, write strobe 1 and output enable 1 shows read-valid 1 in the next cycle. Its read data is then the word held before that edge, so a write to that address on the same edge is not seen. With output enable 0, or during a write, read-valid is 0 and read data is zero.
- R5: Busy is decided from the two enables and the two addresses only. The direction of either access plays no part. If the addresses differ, or either enable is low, both busy outputs are 1 in the next cycle.
- R6: On a collision, a port wins if its enable was already high and its address was unchanged on the previous edge while the other port had just arrived. The newcomer's busy is driven 0 in the next cycle.
- R7: The two busy outputs are never 0 in the same cycle.
- R8: When both ports arrive at the same address on the same edge, the left port wins and only the right busy goes to 0.
- R9: A grant persists as long as both ports stay enabled on the matching address, and the loser's busy stays 0 throughout. The cycle after the match ends, both busy outputs return to 1.
- R10: When both ports write the same address on the same edge, only the winning port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of flags and arbitration state |
| l_en | input | 1 | Left port enable |
| l_wr_n | input | 1 | Left write strobe, 0 = write, 1 = read |
| l_oe | input | 1 | Left output enable |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_n | output | 1 | Left busy, active low |
| r_en | input | 1 | Right port enable |
| r_wr_n | input | 1 | Right write strobe, 0 = write, 1 = read |
| r_oe | input | 1 | Right output enable |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_n | output | 1 | Right busy, active low |

## Verification
The assertions assume that reset is held low across the first clock edge, so the arbitration history and the output flags start from a known state. Beyond that, the busy properties accept any input values.

The stimulus keeps every input constant between edges and changes it one time unit after a rising edge. Each arrival order is therefore determined by the edge at which a port's enable and address were first sampled. The bench inserts an idle cycle before each pair of addresses in the sweep, so that every address pair is a fresh simultaneous arrival. Separate directed sequences stagger the arrivals by one edge in each direction.

// File: rtl/dpram_arb_pkg.sv
// Shared types for the arbitrated dual-port memory.
// Assumes two ports: index 0 is left, index 1 is right.
package dpram_arb_pkg;
    localparam int NPORT = 2;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_t;
endpackage

// File: rtl/dpram_arb_ctl.sv
// Same-address arbiter. Decides, for the inputs at the current edge, which
// port (if any) loses a collision. It keeps the previous edge's enable and
// address to tell an established port from a newcomer, and remembers the
// current owner so that a grant persists while the match lasts.
// Assumes the inputs are synchronous to clk.
module dpram_arb_ctl
    import dpram_arb_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        en,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    output logic [1:0]        lose
);
    logic [1:0]        prev_en;
    logic [ADDR_W-1:0] prev_l, prev_r;
    logic [1:0]        stable;
    logic              match;
    owner_t            owner_q, owner_d;

    // Collision detect and per-port stability against the previous edge.
    always_comb begin
        match     = en[0] & en[1] & (addr_l == addr_r);
        stable[0] = prev_en[0] & (prev_l == addr_l);
        stable[1] = prev_en[1] & (prev_r == addr_r);
    end

    // Owner decision: keep an existing owner, otherwise first arrival, left on a tie.
    always_comb begin
        owner_d = OWN_NONE;
        if (match) begin
            if (owner_q != OWN_NONE)
                owner_d = owner_q;
            else if (stable[1] && !stable[0])
                owner_d = OWN_RIGHT;
            else
                owner_d = OWN_LEFT;
        end
    end

    // The loser is the port opposite the owner.
    always_comb begin
        lose[0] = (owner_d == OWN_RIGHT);
        lose[1] = (owner_d == OWN_LEFT);
    end

    // History registers for arrival order and the held grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en <= '0;
            prev_l  <= '0;
            prev_r  <= '0;
            owner_q <= OWN_NONE;
        end else begin
            prev_en <= en;
            prev_l  <= addr_l;
            prev_r  <= addr_r;
            owner_q <= owner_d;
        end
    end

    // R6
    newcomer_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && owner_q == OWN_NONE && stable[0] && !stable[1]) |-> lose[1]);
endmodule

// File: rtl/dpram_arb_mem.sv
// Storage array with one read and one write path per port. Reads are
// registered and return the word held before the edge. Assumes the
// arbiter never lets two write enables target the same word on one edge.
module dpram_arb_mem
    import dpram_arb_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0]             we,
    input  logic [NPORT-1:0][ADDR_W-1:0] addr,
    input  logic [NPORT-1:0][DATA_W-1:0] wdata,
    output logic [NPORT-1:0][DATA_W-1:0] rq
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit the enabled writes.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++)
            if (we[p]) mem[addr[p]] <= wdata[p];
    end

    // Registered read of every port, giving the old data on a same-edge write.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++)
            rq[p] <= mem[addr[p]];
    end

    // R3
    wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we[0] && we[1] && addr[0] == addr[1]));
endmodule

// File: rtl/dpram_arb_port.sv
// Per-port control. Decodes enable, strobe and output enable, gates the
// write with the arbiter's lose flag, and registers read-valid and busy.
// Assumes the lose flag refers to the same edge as the inputs.
module dpram_arb_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_n,
    input  logic              oe,
    input  logic              lose,
    input  logic [DATA_W-1:0] mem_q,
    output logic              we,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic              busy_n
);
    // Write request, suppressed when this port lost arbitration.
    always_comb we = en & ~wr_n & ~lose;

    // Output flags describing the access sampled at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            busy_n <= 1'b1;
        end else begin
            rvalid <= en & wr_n & oe;
            busy_n <= ~lose;
        end
    end

    // Disabled output reads as zero.
    always_comb rdata = rvalid ? mem_q : '0;
endmodule

// File: rtl/dpram_arb.sv
// Top level: two-port memory with same-address arbitration. Packs the
// left/right pins into per-port vectors, instantiates the port controls,
// the arbiter and the array. Assumes synchronous inputs and a reset held
// across the first edge.
module dpram_arb
    import dpram_arb_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              l_wr_n,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    output logic              l_busy_n,
    input  logic              r_en,
    input  logic              r_wr_n,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid,
    output logic              r_busy_n
);
    logic [NPORT-1:0]             en_v, wr_n_v, oe_v, lose_v, we_v, rvalid_v, busy_v;
    logic [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic [NPORT-1:0][DATA_W-1:0] wdata_v, mq_v, rdata_v;

    // Pin packing into port-indexed vectors.
    always_comb begin
        en_v    = {r_en, l_en};
        wr_n_v  = {r_wr_n, l_wr_n};
        oe_v    = {r_oe, l_oe};
        addr_v  = {r_addr, l_addr};
        wdata_v = {r_wdata, l_wdata};
    end

    dpram_arb_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_v),
        .addr_l (l_addr),
        .addr_r (r_addr),
        .lose   (lose_v)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpram_arb_port #(.DATA_W(DATA_W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_v[p]),
            .wr_n   (wr_n_v[p]),
            .oe     (oe_v[p]),
            .lose   (lose_v[p]),
            .mem_q  (mq_v[p]),
            .we     (we_v[p]),
            .rvalid (rvalid_v[p]),
            .rdata  (rdata_v[p]),
            .busy_n (busy_v[p])
        );
    end

    dpram_arb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_v),
        .addr  (addr_v),
        .wdata (wdata_v),
        .rq    (mq_v)
    );

    // Output unpacking.
    always_comb begin
        l_rdata  = rdata_v[0];
        r_rdata  = rdata_v[1];
        l_rvalid = rvalid_v[0];
        r_rvalid = rvalid_v[1];
        l_busy_n = busy_v[0];
        r_busy_n = busy_v[1];
    end

    // R7
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    // R5
    busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_en && r_en && l_addr == r_addr) |=> (l_busy_n && r_busy_n));

    // R9
    hold_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && r_en && l_addr == r_addr && !r_busy_n) |=> !r_busy_n);

    // R9
    hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && r_en && l_addr == r_addr && !l_busy_n) |=> !l_busy_n);

    // R2
    off_quiet_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !l_en |=> (!l_rvalid && l_rdata == '0));

    // R2
    off_quiet_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_en |=> (!r_rvalid && r_rdata == '0));
endmodule

// File: tb/test_dpram_arb.sv
// Self-checking bench on a 16 x 8 configuration: full fill and readback,
// a sweep over all address pairs, and directed arbitration sequences.
module test_dpram_arb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_en = 0, l_wr_n = 1, l_oe = 0, r_en = 0, r_wr_n = 1, r_oe = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_rvalid, r_rvalid, l_busy_n, r_busy_n;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    logic [DW-1:0] exp_mem [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_arb (
        .clk(clk), .rst_n(rst_n),
        .l_en(l_en), .l_wr_n(l_wr_n), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_busy_n(l_busy_n),
        .r_en(r_en), .r_wr_n(r_wr_n), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_busy_n(r_busy_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drv_l(input logic en, input logic wr_n, input logic oe,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_en = en; l_wr_n = wr_n; l_oe = oe; l_addr = a; l_wdata = d;
    endtask

    task automatic drv_r(input logic en, input logic wr_n, input logic oe,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_en = en; r_wr_n = wr_n; r_oe = oe; r_addr = a; r_wdata = d;
    endtask

    // Advance one edge; outputs then describe the access just sampled.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drv_l(0, 1, 0, '0, '0);
        drv_r(0, 1, 0, '0, '0);
        tick();
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37 + 11) % 256);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #1;
        tick(); tick();
        // Reset state: R2 flags low, R5 busy high
        chk("R2 reset l_rvalid", l_rvalid, 0);
        chk("R2 reset r_rvalid", r_rvalid, 0);
        chk("R5 reset l_busy_n", l_busy_n, 1);
        chk("R5 reset r_busy_n", r_busy_n, 1);
        rst_n = 1'b1;

        // Fill every word from the left (R1, R3)
        for (int a = 0; a < DEPTH; a++) begin
            drv_l(1, 0, 1, AW'(a), pat(a));
            drv_r(0, 1, 1, '0, '0);
            tick();
            exp_mem[a] = pat(a);
            chk("R4 write gives no l_rvalid", l_rvalid, 0);
            chk("R2 idle right r_rvalid", r_rvalid, 0);
        end
        // Read back from the right (R1, R4)
        for (int a = 0; a < DEPTH; a++) begin
            drv_l(0, 1, 0, '0, '0);
            drv_r(1, 1, 1, AW'(a), '0);
            tick();
            chk("R1 readback r_rdata", r_rdata, exp_mem[a]);
            chk("R4 read r_rvalid", r_rvalid, 1);
        end
        // Output enable low suppresses data (R4)
        drv_l(1, 1, 0, 4'd6, '0);
        drv_r(0, 1, 0, '0, '0);
        tick();
        chk("R4 oe low l_rvalid", l_rvalid, 0);
        chk("R4 oe low l_rdata", l_rdata, 0);
        // Disabled port with write strobe low writes nothing (R2)
        drv_l(0, 0, 1, 4'd3, 8'hAA);
        tick();
        chk("R2 disabled l_rvalid", l_rvalid, 0);
        chk("R2 disabled l_rdata", l_rdata, 0);
        drv_l(1, 1, 1, 4'd3, '0);
        tick();
        chk("R2 disabled write ignored", l_rdata, exp_mem[3]);

        // Sweep all address pairs, simultaneous arrival (R5, R8, R7, R4)
        for (int la = 0; la < DEPTH; la++) begin
            for (int ra = 0; ra < DEPTH; ra++) begin
                idle();
                drv_l(1, 1, 1, AW'(la), '0);
                drv_r(1, 1, 1, AW'(ra), '0);
                tick();
                chk(la == ra ? "R8 tie r_busy_n" : "R5 differ r_busy_n",
                    r_busy_n, (la == ra) ? 0 : 1);
                chk("R7 tie l_busy_n high", l_busy_n, 1);
                chk("R4 sweep l_rdata", l_rdata, exp_mem[la]);
                chk("R4 sweep r_rdata", r_rdata, exp_mem[ra]);
            end
        end
        // Matching address with one enable low: no busy (R5)
        for (int a = 0; a < DEPTH; a += 5) begin
            idle();
            drv_l(0, 0, 1, AW'(a), 8'h00);
            drv_r(1, 0, 1, AW'(a), exp_mem[a]);
            tick();
            chk("R5 enable low l_busy_n", l_busy_n, 1);
            chk("R5 enable low r_busy_n", r_busy_n, 1);
        end

        // Left first, right writes later: right busy, write blocked (R6, R3, R9)
        idle();
        drv_l(1, 1, 1, 4'd5, '0);
        tick();
        chk("R5 alone l_busy_n", l_busy_n, 1);
        drv_r(1, 0, 1, 4'd5, 8'h5A);
        tick();
        chk("R6 newcomer r_busy_n", r_busy_n, 0);
        chk("R6 owner l_busy_n", l_busy_n, 1);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R9 held r_busy_n", r_busy_n, 0);
            chk("R3 blocked write invisible", l_rdata, exp_mem[5]);
        end
        drv_l(1, 1, 1, 4'd6, '0);
        tick();
        chk("R9 released r_busy_n", r_busy_n, 1);
        exp_mem[5] = 8'h5A;
        idle();
        drv_l(1, 1, 1, 4'd5, '0);
        tick();
        chk("R3 write after release", l_rdata, exp_mem[5]);

        // Right first, left later: left busy (R6)
        idle();
        drv_r(1, 1, 1, 4'd9, '0);
        tick();
        drv_l(1, 1, 1, 4'd9, '0);
        tick();
        chk("R6 newcomer l_busy_n", l_busy_n, 0);
        chk("R6 owner r_busy_n", r_busy_n, 1);
        drv_r(0, 1, 1, 4'd9, '0);
        tick();
        chk("R9 release on enable drop", l_busy_n, 1);

        // Both write the same word on one edge: left data kept (R10, R8)
        idle();
        drv_l(1, 0, 1, 4'd7, 8'h11);
        drv_r(1, 0, 1, 4'd7, 8'h22);
        tick();
        chk("R8 double write r_busy_n", r_busy_n, 0);
        exp_mem[7] = 8'h11;
        idle();
        drv_r(1, 1, 1, 4'd7, '0);
        tick();
        chk("R10 winner data kept", r_rdata, exp_mem[7]);

        // Read on the edge of a write to the same word returns old data (R4)
        idle();
        drv_l(1, 0, 1, 4'd2, 8'hC3);
        drv_r(1, 1, 1, 4'd2, '0);
        tick();
        chk("R4 old data on same-edge write", r_rdata, exp_mem[2]);
        chk("R4 r_rvalid with write", r_rvalid, 1);
        exp_mem[2] = 8'hC3;
        drv_l(0, 1, 0, '0, '0);
        tick();
        chk("R1 new data next read", r_rdata, exp_mem[2]);

        // Two writes to different words both commit (R3)
        idle();
        drv_l(1, 0, 1, 4'd0, 8'h01);
        drv_r(1, 0, 1, 4'd1, 8'h02);
        tick();
        chk("R5 differ writes l_busy_n", l_busy_n, 1);
        chk("R5 differ writes r_busy_n", r_busy_n, 1);
        exp_mem[0] = 8'h01;
        exp_mem[1] = 8'h02;
        drv_l(1, 1, 1, 4'd1, '0);
        drv_r(1, 1, 1, 4'd0, '0);
        tick();
        chk("R3 both commit left view", l_rdata, exp_mem[1]);
        chk("R3 both commit right view", r_rdata, exp_mem[0]);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule